// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches the control and address lines of an asynchronous-style memory bus, sampled on a clock. It recognises a hidden command. The command is a run of six consecutive read accesses, and each read must go to its own predefined address in a fixed order. When the sixth matching read is seen, the block raises a store-request pulse for one clock. The pulse is meant for a separate store engine, which answers with a busy signal.

Any access that breaks the run cancels the sequence. A write breaks it, and so does a read to an address other than the one expected next. The block then waits again for the first address. If the breaking read is itself at the first address, it starts a new run at once. While the store engine works, the block ignores the bus until busy has been raised and then dropped.

The state machine has five named states:

- `ST_IDLE` waits at step zero.
- `ST_TRACK` holds the count of matched reads.
- `ST_ISSUE` drives the pulse.
- `ST_WAIT_BUSY` waits for busy to rise.
- `ST_HOLD` waits for busy to fall.

Transitions:

- idle→track on a first-address read.
- track→track on the expected read or on a restart at the first address.
- track→idle on a write or a foreign read.
- track→issue on the final read.
- issue→wait_busy always.
- wait_busy→hold when busy is high.
- hold→idle when busy is low.
- Any state→idle on reset.

Top module: `rdseq_cmd_detect`

## Requirements
- R1: A read access is `cs_n`=0, `oe_n`=0, `we_n`=1 at a clock edge. With `cs_n`=0, `oe_n`=1, `we_n`=1 nothing is accessed. With `cs_n`=1 the bus is ignored whatever the other lines are. Neither of these two states moves or cancels the sequence.
- R2: A write access is `cs_n`=0, `we_n`=0. A write during a partial sequence cancels it, so the remaining reads produce no pulse.
- R3: Default addresses in order are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0. When the sixth matching read is sampled at a clock edge, `cmd_pulse` is high for exactly the following clock cycle.
- R4: During a partial sequence, a read from an address that is neither the expected next one nor the first one cancels the sequence, and no pulse follows.
- R5: During a partial sequence, a read at the first address that is not the expected next address restarts the sequence with that read counted as step one.
- R6: An access counts once, in the first cycle it is sampled or in a cycle where its address differs from the previous cycle. A read held for several clocks advances one step, and a run done with `cs_n` held low and only the address changing is recognised.
- R7: After a pulse, all bus activity is ignored until `busy` has been seen high and then low. Detection resumes in the cycle after `busy` is seen low.
- R8: A synchronous active-high `rst` returns the detector to idle at step zero. A partial sequence interrupted by reset is forgotten.
- R9: Directly after reset, `cmd_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Access address |
| busy | input | 1 | Store engine working |
| cmd_pulse | output | 1 | One-cycle store request |

## Verification
The hardest situation to reach from the ports is the restart: an aborting read that is itself the first address must count as step one of a new run. The stimulus reads the first two addresses, reads the first address again, then continues from the second address through the sixth. Only a correct same-cycle restart yields exactly one pulse. The quiet window after a pulse is reached by playing full sequences both before and while the bench raises `busy`.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRACK,
        ST_ISSUE,
        ST_WAIT_BUSY,
        ST_HOLD
    } seq_state_t;

endpackage

// File: rtl/rdseq_access_edge.sv
// Turns the sampled bus levels into single-cycle access events (R1, R2, R6).
module rdseq_access_edge #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_ev,
    output logic              wr_ev
);

    logic              rd_lvl;
    logic              wr_lvl;
    logic              rd_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        rd_lvl = !cs_n && !oe_n && we_n;
        wr_lvl = !cs_n && !we_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            rd_q   <= rd_lvl;
            wr_q   <= wr_lvl;
            addr_q <= addr;
        end
    end

    always_comb begin
        rd_ev = rd_lvl && (!rd_q || (addr != addr_q));
        wr_ev = wr_lvl && (!wr_q || (addr != addr_q));
    end

    // R6: a held read at a steady address produces no second event
    a_r6_read_once: assert property (@(posedge clk) disable iff (rst)
        rd_ev |=> (!rd_ev || !$stable(addr)));

endmodule

// File: rtl/rdseq_addr_match.sv
// Compares the bus address against every step address in parallel.
module rdseq_addr_match #(
    parameter int                          ADDR_W  = 15,
    parameter int                          N_STEPS = 6,
    parameter logic [N_STEPS*ADDR_W-1:0]   SEQ_ADDRS = '0
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_STEPS-1:0] hit
);

    for (genvar gi = 0; gi < N_STEPS; gi++) begin : g_cmp
        assign hit[gi] = (addr == SEQ_ADDRS[gi*ADDR_W +: ADDR_W]);
    end

endmodule

// File: rtl/rdseq_fsm.sv
// Sequence tracker and store-request handshake.
module rdseq_fsm
    import rdseq_pkg::*;
#(
    parameter int N_STEPS = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_ev,
    input  logic               wr_ev,
    input  logic [N_STEPS-1:0] hit,
    input  logic               busy,
    output logic               cmd_pulse
);

    localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

    seq_state_t        st, st_n;
    logic [STEP_W-1:0] step, step_n;
    logic              exp_hit;
    logic              at_last;

    always_comb begin
        exp_hit = 1'b0;
        for (int i = 0; i < N_STEPS; i++) begin
            if (step == STEP_W'(i)) exp_hit = hit[i];
        end
        at_last = (step == LAST);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            step <= '0;
        end else begin
            st   <= st_n;
            step <= step_n;
        end
    end

    // Next state
    always_comb begin
        st_n   = st;
        step_n = step;
        unique case (st)
            ST_IDLE: begin
                if (rd_ev && hit[0]) begin
                    if (N_STEPS == 1) begin
                        st_n   = ST_ISSUE;
                        step_n = '0;
                    end else begin
                        st_n   = ST_TRACK;
                        step_n = STEP_W'(1);
                    end
                end
            end
            ST_TRACK: begin
                if (wr_ev) begin
                    st_n   = ST_IDLE;
                    step_n = '0;
                end else if (rd_ev) begin
                    if (exp_hit) begin
                        if (at_last) begin
                            st_n   = ST_ISSUE;
                            step_n = '0;
                        end else begin
                            step_n = step + STEP_W'(1);
                        end
                    end else if (hit[0]) begin
                        step_n = STEP_W'(1);
                    end else begin
                        st_n   = ST_IDLE;
                        step_n = '0;
                    end
                end
            end
            ST_ISSUE: begin
                st_n = ST_WAIT_BUSY;
            end
            ST_WAIT_BUSY: begin
                if (busy) st_n = ST_HOLD;
            end
            ST_HOLD: begin
                if (!busy) st_n = ST_IDLE;
            end
            default: begin
                st_n   = ST_IDLE;
                step_n = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cmd_pulse = (st == ST_ISSUE);
    end

    // R3: pulse lasts one cycle
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse |=> !cmd_pulse);

    // R3: pulse only follows a final matching read while tracking
    a_r3_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse |-> $past(st == ST_TRACK && rd_ev && exp_hit && at_last));

    // R2: a write while tracking sends the tracker home
    a_r2_write_abort: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRACK && wr_ev) |=> (st == ST_IDLE && step == '0));

    // R4: a foreign read while tracking sends the tracker home
    a_r4_foreign_abort: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRACK && rd_ev && !wr_ev && !exp_hit && !hit[0])
            |=> (st == ST_IDLE));

    // R7: the busy hold is left only through a low busy
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && busy) |=> (st == ST_HOLD));

    // R8: reset lands in idle at step zero
    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (st == ST_IDLE && step == '0 && !cmd_pulse));

endmodule

// File: rtl/rdseq_cmd_detect.sv
module rdseq_cmd_detect #(
    parameter int                        ADDR_W    = 15,
    parameter int                        N_STEPS   = 6,
    parameter logic [N_STEPS*ADDR_W-1:0] SEQ_ADDRS = {
        15'h0FC0, 15'h303F, 15'h3C1F, 15'h03E0, 15'h31C7, 15'h0E38
    }
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output logic              cmd_pulse
);

    logic               rd_ev;
    logic               wr_ev;
    logic [N_STEPS-1:0] hit;

    rdseq_access_edge #(
        .ADDR_W (ADDR_W)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .addr  (addr),
        .rd_ev (rd_ev),
        .wr_ev (wr_ev)
    );

    rdseq_addr_match #(
        .ADDR_W    (ADDR_W),
        .N_STEPS   (N_STEPS),
        .SEQ_ADDRS (SEQ_ADDRS)
    ) u_match (
        .addr (addr),
        .hit  (hit)
    );

    rdseq_fsm #(
        .N_STEPS (N_STEPS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rd_ev     (rd_ev),
        .wr_ev     (wr_ev),
        .hit       (hit),
        .busy      (busy),
        .cmd_pulse (cmd_pulse)
    );

endmodule

// File: tb/rdseq_cmd_detect_test.sv
module rdseq_cmd_detect_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [14:0] addr = '0;
    logic        busy = 1'b0;
    logic        cmd_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    localparam logic [14:0] JUNK = 15'h1234;

    always #5 clk = ~clk;

    rdseq_cmd_detect uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .busy(busy), .cmd_pulse(cmd_pulse)
    );

    function automatic logic [14:0] seq_at(input int i);
        case (i)
            0: return 15'h0E38;
            1: return 15'h31C7;
            2: return 15'h03E0;
            3: return 15'h3C1F;
            4: return 15'h303F;
            default: return 15'h0FC0;
        endcase
    endfunction

    always @(negedge clk) if (!rst && cmd_pulse) pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_idle(input int n);
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [14:0] a, input int n);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        repeat (n) @(negedge clk);
        bus_idle(1);
    endtask

    task automatic wr(input logic [14:0] a);
        cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a;
        @(negedge clk);
        bus_idle(1);
    endtask

    task automatic run_seq(input int from, input int upto);
        for (int i = from; i <= upto; i++) rd(seq_at(i), 1);
    endtask

    task automatic engine_cycle();
        busy = 1'b1;
        repeat (3) @(negedge clk);
        busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_idle(2);
        rst = 1'b0;
        bus_idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        check(cmd_pulse == 1'b0, "R9 pulse low after reset", cmd_pulse, 0);
        check(pulses == 0, "R9 no pulse counted", pulses, 0);
    endtask

    task automatic t_basic();
        int p0 = pulses;
        run_seq(0, 4);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = seq_at(5);
        @(negedge clk);
        check(cmd_pulse == 1'b1, "R3 pulse after sixth read", cmd_pulse, 1);
        bus_idle(1);
        check(cmd_pulse == 1'b0, "R3 pulse one cycle", cmd_pulse, 0);
        check(pulses - p0 == 1, "R3 one pulse", pulses - p0, 1);
        engine_cycle();
    endtask

    task automatic t_write_abort();
        int p0 = pulses;
        run_seq(0, 2);
        wr(JUNK);
        run_seq(3, 5);
        check(pulses - p0 == 0, "R2 write aborts", pulses - p0, 0);
        run_seq(0, 5);
        check(pulses - p0 == 1, "R2 recovers after abort", pulses - p0, 1);
        engine_cycle();
    endtask

    task automatic t_bad_addr();
        int p0 = pulses;
        run_seq(0, 3);
        rd(JUNK, 1);
        run_seq(4, 5);
        check(pulses - p0 == 0, "R4 foreign read aborts", pulses - p0, 0);
        run_seq(0, 0);
        rd(seq_at(2), 1);
        run_seq(2, 5);
        check(pulses - p0 == 0, "R4 skipped step aborts", pulses - p0, 0);
    endtask

    task automatic t_restart();
        int p0 = pulses;
        run_seq(0, 1);
        rd(seq_at(0), 1);
        run_seq(1, 5);
        check(pulses - p0 == 1, "R5 restart on first address", pulses - p0, 1);
        engine_cycle();
    endtask

    task automatic t_nonread();
        int p0 = pulses;
        run_seq(0, 1);
        cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = JUNK;
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = JUNK;
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b0; addr = JUNK;
        @(negedge clk);
        bus_idle(1);
        run_seq(2, 5);
        check(pulses - p0 == 1, "R1 non-accesses ignored", pulses - p0, 1);
        engine_cycle();
    endtask

    task automatic t_held();
        int p0 = pulses;
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            addr = seq_at(i);
            repeat (3) @(negedge clk);
        end
        bus_idle(1);
        check(pulses - p0 == 1, "R6 held reads with cs low", pulses - p0, 1);
        engine_cycle();
        rd(seq_at(0), 4);
        run_seq(1, 5);
        check(pulses - p0 == 2, "R6 long read counts once", pulses - p0, 2);
        engine_cycle();
    endtask

    task automatic t_busy();
        int p0 = pulses;
        run_seq(0, 5);
        check(pulses - p0 == 1, "R7 first pulse", pulses - p0, 1);
        run_seq(0, 5);
        check(pulses - p0 == 1, "R7 ignored before busy", pulses - p0, 1);
        busy = 1'b1;
        @(negedge clk);
        run_seq(0, 5);
        check(pulses - p0 == 1, "R7 ignored while busy", pulses - p0, 1);
        busy = 1'b0;
        @(negedge clk);
        run_seq(0, 5);
        check(pulses - p0 == 2, "R7 resumes after busy", pulses - p0, 2);
        engine_cycle();
    endtask

    task automatic t_sync_reset();
        int p0 = pulses;
        run_seq(0, 2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        run_seq(3, 5);
        check(pulses - p0 == 0, "R8 reset forgets progress", pulses - p0, 0);
        check(cmd_pulse == 1'b0, "R8 pulse low", cmd_pulse, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_write_abort();
        t_bad_addr();
        t_restart();
        t_nonread();
        t_held();
        t_busy();
        t_sync_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule